// File: doc/BRIEF.md
# Counter-Domain Control Register with Synchronized Enable and Soft Reset

This block is the 16-bit control register of a real-time counter peripheral. Software writes and reads it through a plain register port in the bus clock domain. The block keeps the count-read sync enable, two tamper-reset enables, a prescaler code, a mode code, the run enable and a self-clearing soft reset. It delivers the run state, the mode and a prescaled tick to logic that runs on a separate counter clock.

The enable and the soft reset each cross into the counter domain through a toggle request. The request passes a two-flop synchronizer, and its acknowledgment comes back the same way. While a crossing is pending, a busy flag is visible on the bus side. The mode and prescaler codes are captured together with each enable request, so the counter domain receives them as one coherent set.

A power-of-two prescaler runs in the counter domain and emits a one-cycle tick at the selected division. It restarts from zero each time an enable or reset request is applied. The register port has no back-pressure: a write strobe is taken in the cycle it is presented, and a write that the rules below reject simply leaves the affected fields unchanged.

Top module: `tcr_top`

## Requirements
- R1: After reset, the register reads 0x0000. Read layout: bit 15 is the count-read sync enable, bit 14 the general-purpose tamper reset, bit 13 the backup tamper reset, bits 11:8 the prescaler code, bits 3:2 the mode code, bit 1 the enable and bit 0 the soft reset. Bits 12 and 7:4 always read 0.
- R2: A write with bit 0 set discards every other field of that write. It clears all fields, and the register reads 0x0001 in the cycle after the write.
- R3: The soft reset bit clears itself only after the counter domain has applied the reset. It then reads 0x0000, and the counter outputs show disabled, mode 0 and event-enable 0. Writes made while the bit is 1 are ignored.
- R4: A write that changes bit 1 reads back the new value in the next cycle and raises `busy_en` at the same time. `busy_en` falls only after the counter domain has applied the new value.
- R5: An enable write made while `busy_en` is high is sent only after the current crossing completes. Once `busy_en` falls, `cnt_enable` equals the last value written.
- R6: Bits 14 and 13 accept writes only while the stored enable is 0.
- R7: While the stored enable is 1, writes to the mode and prescaler fields are ignored. Bit 15 can be written at any time.
- R8: A prescaler code of 12 to 15 leaves the prescaler field unchanged. A mode code of 3 leaves the mode field unchanged.
- R9: While enabled, `cnt_tick` pulses once every D counter cycles. D is 1 for codes 0 and 1, and 2^(code-1) for codes 2 to 11 (code 11 gives 1024).
- R10: `cnt_evt_ok` is 1 only while the counter domain is enabled with a nonzero prescaler code.
- R11: While `cnt_enable` is 0, `cnt_tick` stays 0.
- R12: `cnt_mode` shows the mode code that was stored when the last enable request was sent (0 = 32-bit count, 1 = 16-bit count, 2 = calendar).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, taken in the cycle it is high |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register value |
| busy_en | output | 1 | Enable change not yet applied in the counter domain |
| busy_rst | output | 1 | Soft reset in progress (same as read bit 0) |
| cnt_clk | input | 1 | Counter-domain clock |
| cnt_rst_n | input | 1 | Counter-domain active-low asynchronous reset |
| cnt_enable | output | 1 | Enable as applied in the counter domain |
| cnt_mode | output | 2 | Mode as applied in the counter domain |
| cnt_evt_ok | output | 1 | Periodic events permitted |
| cnt_tick | output | 1 | Prescaled one-cycle counter tick |

## Verification
The assertions check the per-cycle rules on every cycle:
- a write with bit 0 set reads back as 0x0001 in the next cycle;
- fields hold while a soft reset is pending;
- the busy flag rises on an enable change;
- the mode, prescaler and tamper fields hold while enabled;
- reserved prescaler codes are rejected;
- no new request launches while one is in flight;
- the prescaler count stays within its limit.

Only the bench scenarios can show the end-to-end outcomes, because these depend on the clock ratio. These outcomes are the completion of crossings, the deferred enable settling to the last written value, the measured tick periods for several codes, and the absence of ticks while disabled.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int REG_W    = 16;
  localparam int B_CSYNC  = 15;
  localparam int B_GPTAMP = 14;
  localparam int B_BKTAMP = 13;
  localparam int PSC_LO   = 8;
  localparam int PSC_W    = 4;
  localparam int MODE_LO  = 2;
  localparam int B_EN     = 1;
  localparam int B_SRST   = 0;
  localparam logic [PSC_W-1:0] PSC_TOP = 4'd11;

  typedef enum logic [1:0] {
    MODE_C32 = 2'd0,
    MODE_C16 = 2'd1,
    MODE_CAL = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;
endpackage

// File: rtl/tcr_hs.sv
// Toggle request/acknowledge crossing between two clock domains.
module tcr_hs #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic launch,
  output logic busy,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic              req_t;
  logic [STAGES-1:0] ack_s;
  logic [STAGES-1:0] req_s;
  logic              req_seen;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_t <= 1'b0;
      ack_s <= '0;
    end else begin
      if (launch) req_t <= ~req_t;
      ack_s <= {ack_s[STAGES-2:0], req_seen};
    end
  end

  assign busy = req_t ^ ack_s[STAGES-1];

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_s    <= '0;
      req_seen <= 1'b0;
    end else begin
      req_s    <= {req_s[STAGES-2:0], req_t};
      req_seen <= req_s[STAGES-1];
    end
  end

  assign dst_pulse = req_s[STAGES-1] ^ req_seen;

  // R5: a second request never launches over one in flight
  a_r5_launch_idle: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    launch |-> !busy);
endmodule

// File: rtl/tcr_bus_regs.sv
module tcr_bus_regs
  import tcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             en_hs_busy,
  input  logic             rst_hs_busy,
  output logic             en_launch,
  output logic             rst_launch,
  output logic             en_sent,
  output mode_e            mode_sent,
  output logic [PSC_W-1:0] psc_sent,
  output logic             busy_en,
  output logic             busy_rst
);
  logic             csync_q, gptamp_q, bktamp_q, en_q, srst_q;
  logic [PSC_W-1:0] psc_q;
  mode_e            mode_q;
  logic             wr_ok, wr_norm;
  logic [PSC_W-1:0] psc_in;
  logic [1:0]       mode_in;
  logic             srst_done;

  assign wr_ok     = wr_en && !srst_q;
  assign wr_norm   = wr_ok && !wr_data[B_SRST];
  assign psc_in    = wr_data[PSC_LO +: PSC_W];
  assign mode_in   = wr_data[MODE_LO +: 2];
  assign rst_launch = wr_ok && wr_data[B_SRST];
  assign en_launch = !en_hs_busy && (en_q != en_sent);
  assign srst_done = srst_q && !rst_hs_busy && !en_hs_busy && (en_q == en_sent);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csync_q  <= 1'b0;
      gptamp_q <= 1'b0;
      bktamp_q <= 1'b0;
      psc_q    <= '0;
      mode_q   <= MODE_C32;
      en_q     <= 1'b0;
      srst_q   <= 1'b0;
    end else if (rst_launch) begin
      csync_q  <= 1'b0;
      gptamp_q <= 1'b0;
      bktamp_q <= 1'b0;
      psc_q    <= '0;
      mode_q   <= MODE_C32;
      en_q     <= 1'b0;
      srst_q   <= 1'b1;
    end else begin
      if (srst_done) srst_q <= 1'b0;
      if (wr_norm) begin
        csync_q <= wr_data[B_CSYNC];
        en_q    <= wr_data[B_EN];
        if (!en_q) begin
          gptamp_q <= wr_data[B_GPTAMP];
          bktamp_q <= wr_data[B_BKTAMP];
          if (psc_in <= PSC_TOP) psc_q <= psc_in;
          if (mode_in != MODE_RSV) mode_q <= mode_e'(mode_in);
        end
      end
    end
  end

  // Snapshot sent with each enable request; stable while it is in flight.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_sent   <= 1'b0;
      mode_sent <= MODE_C32;
      psc_sent  <= '0;
    end else if (en_launch) begin
      en_sent   <= en_q;
      mode_sent <= mode_q;
      psc_sent  <= psc_q;
    end
  end

  assign busy_en  = en_hs_busy || (en_q != en_sent);
  assign busy_rst = srst_q;

  always_comb begin
    rd_data                     = '0;
    rd_data[B_CSYNC]            = csync_q;
    rd_data[B_GPTAMP]           = gptamp_q;
    rd_data[B_BKTAMP]           = bktamp_q;
    rd_data[PSC_LO +: PSC_W]    = psc_q;
    rd_data[MODE_LO +: 2]       = mode_q;
    rd_data[B_EN]               = en_q;
    rd_data[B_SRST]             = srst_q;
  end

  a_r2_srst_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_SRST] && !srst_q) |=> (rd_data == 16'h0001));
  a_r3_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> $stable({csync_q, gptamp_q, bktamp_q, psc_q, mode_q, en_q}));
  a_r4_busy_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_norm && (wr_data[B_EN] != en_q)) |=> busy_en);
  a_r7_lock_running: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_norm && en_q) |=> $stable({psc_q, mode_q, gptamp_q, bktamp_q}));
  a_r8_psc_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_norm && (psc_in > PSC_TOP)) |=> $stable(psc_q));
endmodule

// File: rtl/tcr_tick_div.sv
// Power-of-two prescaler in the counter domain.
module tcr_tick_div #(
  parameter int PSC_W = 4,
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic [DIV_W:0]   span;

  always_comb begin
    span = (DIV_W+1)'(1);
    if (code > 1) span = (DIV_W+1)'(1) << (code - PSC_W'(1));
    lim = DIV_W'(span - (DIV_W+1)'(1));
  end

  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else if (tick)            cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end

  a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);
  a_r9_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/tcr_cnt_side.sv
module tcr_cnt_side
  import tcr_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pulse,
  input  logic             rst_pulse,
  input  logic             en_data,
  input  mode_e            mode_data,
  input  logic [PSC_W-1:0] psc_data,
  output logic             cnt_enable,
  output logic [1:0]       cnt_mode,
  output logic             cnt_evt_ok,
  output logic             cnt_tick
);
  logic             en_c;
  mode_e            mode_c;
  logic [PSC_W-1:0] psc_c;
  logic             restart;

  assign restart = en_pulse || rst_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_c   <= 1'b0;
      mode_c <= MODE_C32;
      psc_c  <= '0;
    end else if (rst_pulse) begin
      en_c   <= 1'b0;
      mode_c <= MODE_C32;
      psc_c  <= '0;
    end else if (en_pulse) begin
      en_c   <= en_data;
      mode_c <= mode_data;
      psc_c  <= psc_data;
    end
  end

  tcr_tick_div #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_c), .restart(restart),
    .code(psc_c), .tick(cnt_tick)
  );

  assign cnt_enable = en_c;
  assign cnt_mode   = mode_c;
  assign cnt_evt_ok = en_c && (psc_c != '0);

  a_r3_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> (!cnt_enable && !cnt_evt_ok));
endmodule

// File: rtl/tcr_top.sv
module tcr_top
  import tcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 10
) (
  input  logic        bus_clk,
  input  logic        bus_rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        busy_en,
  output logic        busy_rst,
  input  logic        cnt_clk,
  input  logic        cnt_rst_n,
  output logic        cnt_enable,
  output logic [1:0]  cnt_mode,
  output logic        cnt_evt_ok,
  output logic        cnt_tick
);
  localparam int NCH = 2;
  localparam int CH_EN = 0;
  localparam int CH_RST = 1;

  logic [NCH-1:0]   launch, hs_busy, pulse;
  logic             en_sent;
  mode_e            mode_sent;
  logic [PSC_W-1:0] psc_sent;

  tcr_bus_regs u_regs (
    .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .en_hs_busy(hs_busy[CH_EN]), .rst_hs_busy(hs_busy[CH_RST]),
    .en_launch(launch[CH_EN]), .rst_launch(launch[CH_RST]),
    .en_sent(en_sent), .mode_sent(mode_sent), .psc_sent(psc_sent),
    .busy_en(busy_en), .busy_rst(busy_rst)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tcr_hs #(.STAGES(SYNC_STAGES)) u_hs (
      .src_clk(bus_clk), .src_rst_n(bus_rst_n), .launch(launch[g]),
      .busy(hs_busy[g]), .dst_clk(cnt_clk), .dst_rst_n(cnt_rst_n),
      .dst_pulse(pulse[g])
    );
  end

  tcr_cnt_side #(.DIV_W(DIV_W)) u_cnt (
    .clk(cnt_clk), .rst_n(cnt_rst_n), .en_pulse(pulse[CH_EN]),
    .rst_pulse(pulse[CH_RST]), .en_data(en_sent), .mode_data(mode_sent),
    .psc_data(psc_sent), .cnt_enable(cnt_enable), .cnt_mode(cnt_mode),
    .cnt_evt_ok(cnt_evt_ok), .cnt_tick(cnt_tick)
  );
endmodule

// File: tb/tcr_top_bench.sv
module tcr_top_bench;
  logic        bus_clk = 1'b0, cnt_clk = 1'b0;
  logic        bus_rst_n = 1'b0, cnt_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        busy_en, busy_rst, cnt_enable, cnt_evt_ok, cnt_tick;
  logic [1:0]  cnt_mode;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 bus_clk = ~bus_clk;
  always #3.5 cnt_clk = ~cnt_clk;

  tcr_top u_tcr_top (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy_en(busy_en), .busy_rst(busy_rst),
    .cnt_clk(cnt_clk), .cnt_rst_n(cnt_rst_n), .cnt_enable(cnt_enable),
    .cnt_mode(cnt_mode), .cnt_evt_ok(cnt_evt_ok), .cnt_tick(cnt_tick)
  );

  // {write data, expected read-back}, all taken while disabled
  localparam logic [31:0] VEC [0:6] = '{
    32'h8000_8000,  // R1 sync bit
    32'h6000_6000,  // R6 tamper bits while disabled
    32'hF0F0_E000,  // R1 unimplemented bits read 0
    32'h0B0C_0B00,  // R8 mode 3 rejected
    32'h0C04_0B04,  // R8 prescaler 12 rejected
    32'h0308_0308,
    32'h0000_0000
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!busy_en && !busy_rst) break;
      @(negedge bus_clk);
    end
  endtask

  task automatic period(output int p);
    p = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge cnt_clk);
      if (cnt_tick) break;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge cnt_clk);
      p++;
      if (cnt_tick) break;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, n;
    repeat (3) @(negedge bus_clk);
    bus_rst_n = 1'b1; cnt_rst_n = 1'b1;
    @(negedge bus_clk);
    check("R1 reset value", rd_data, 32'h0);
    check("R1 reset busy", {busy_en, busy_rst}, 0);
    check("R11 reset disabled", {cnt_enable, cnt_tick}, 0);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][31:16]);
      check($sformatf("R1/R6/R8 vector %0d", i), rd_data, VEC[i][15:0]);
    end

    // enable: div 4, mode 1
    wr(16'h0306);
    check("R4 immediate readback", rd_data, 16'h0306);
    check("R4 busy raised", busy_en, 1);
    wait_idle();
    check("R4 busy cleared", busy_en, 0);
    check("R4 applied", cnt_enable, 1);
    check("R12 mode applied", cnt_mode, 2'd1);
    check("R10 events on", cnt_evt_ok, 1);
    period(p);
    check("R9 code 3 divides by 4", p, 4);

    // locked fields while running
    wr(16'h650A);
    check("R6 R7 locked while enabled", rd_data, 16'h0306);
    wr(16'h850A);
    check("R7 sync bit writable while enabled", rd_data, 16'h8306);
    period(p);
    check("R7 prescaler unchanged at port", p, 4);

    // enable write held off behind a pending crossing
    wr(16'h8304);
    wr(16'h8306);
    check("R5 readback of latest", rd_data, 16'h8306);
    wait_idle();
    check("R5 settles to last written", cnt_enable, 1);

    // disable: no ticks
    wr(16'h0304);
    wait_idle();
    check("R11 disabled", cnt_enable, 0);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge cnt_clk);
      if (cnt_tick) n++;
    end
    check("R11 no ticks while disabled", n, 0);

    // code 0: divide by 1, events off
    wr(16'h0006);
    wait_idle();
    check("R10 events off at code 0", cnt_evt_ok, 0);
    period(p);
    check("R9 code 0 divides by 1", p, 1);

    // code 11: divide by 1024, calendar mode
    wr(16'h0000);
    wait_idle();
    wr(16'h0B0A);
    wait_idle();
    check("R12 calendar mode", cnt_mode, 2'd2);
    check("R10 events on at code 11", cnt_evt_ok, 1);
    period(p);
    check("R9 code 11 divides by 1024", p, 1024);

    // soft reset overrides its own write
    wr(16'hE30B);
    check("R2 other fields discarded", rd_data, 16'h0001);
    check("R3 reset busy", busy_rst, 1);
    wr(16'h8000);
    check("R3 write ignored during reset", rd_data, 16'h0001);
    wait_idle();
    check("R3 self-cleared", rd_data, 16'h0000);
    check("R3 counter side reset", {cnt_enable, cnt_mode, cnt_evt_ok}, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule